// File: doc/BRIEF.md
# Doorbell Interrupt Register Block

This block is a small bank of 32-bit registers on a single-cycle register bus, with one level interrupt output. It keeps two outbound descriptor words, a control word, an interrupt status word and a software interrupt word. Software signals the other side by writing these registers. The interrupt line is not computed from a status and mask pair. It is a flop that particular writes set or clear, chosen by the target register and, for some registers, by single bits of the written data.

A write goes in when `bus_wr` is high at a rising clock edge. A read is combinational: while `bus_rd` is high, `bus_rdata` shows the addressed register's current value. At any other time `bus_rdata` is zero. Only whole aligned 32-bit words are decoded. Any address that does not exactly match a register offset is unmapped.

Top module: `doorbell_regs`

## Requirements
- R1: After reset all five stored words are zero and `irq_o` is low. A read of control then returns 0x0002_0000.
- R2: A write at 0x28 stores the full word into descriptor A, and reads at 0x28 return it. This write leaves `irq_o` unchanged.
- R3: A write at 0x2C stores the full word into descriptor B, and reads at 0x2C return it. If data bit 29 is 1, `irq_o` is high after the edge. Otherwise `irq_o` is unchanged.
- R4: A write at 0x4C stores the word into control. A read at 0x4C returns the stored word with bit 17 forced to 1. If data bit 16 is 1, `irq_o` is low after the edge. Otherwise `irq_o` is unchanged.
- R5: A write at 0x50 stores the word into status, and reads at 0x50 return it. If data bit 16 or data bit 29 is 1, `irq_o` is low after the edge. Otherwise `irq_o` is unchanged.
- R6: A write at 0x1F0 ORs the data into the software word. It always makes `irq_o` high after the edge, even when the data is zero.
- R7: A write at 0x1F4 clears the software word bits that are 1 in the data, and it always makes `irq_o` low after the edge. Reads at both 0x1F0 and 0x1F4 return the software word.
- R8: Reads at unmapped addresses return zero. Writes at unmapped addresses change no stored word and leave `irq_o` unchanged. When `bus_rd` is low, `bus_rdata` is zero.
- R9: `irq_o` changes only on the clock edge that accepts a write, and holds its value in every cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, sampled at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, combinational |
| irq_o | output | 1 | Level interrupt output, registered |

## Verification
The embedded properties check the interrupt rules on every cycle:
- a raise after a descriptor B write with bit 29 set and after any software set write;
- a drop after qualifying control and status writes and after any software clear write;
- the line holding through idle cycles and unmapped writes;
- the forced control bit and zero data for unmapped reads.

Only the bench's scenarios can show that stored values read back correctly and that the software word accumulates across set and clear writes. They also cover the reset contents, since these depend on the history of writes and not on a single cycle.

// File: rtl/doorbell_regs.sv
module doorbell_regs #(
  parameter int AW          = 12,
  parameter int DW          = 32,
  parameter logic [AW-1:0] OFF_DESC_A = 12'h028,
  parameter logic [AW-1:0] OFF_DESC_B = 12'h02C,
  parameter logic [AW-1:0] OFF_CTRL   = 12'h04C,
  parameter logic [AW-1:0] OFF_STAT   = 12'h050,
  parameter logic [AW-1:0] OFF_SWSET  = 12'h1F0,
  parameter logic [AW-1:0] OFF_SWCLR  = 12'h1F4,
  parameter int RAISE_BIT   = 29,
  parameter int LOWER_BIT   = 16,
  parameter int FIXED_BIT   = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd,
  output logic [DW-1:0] bus_rdata,
  output logic          irq_o
);
  localparam logic [DW-1:0] FIXED_MASK = DW'(1) << FIXED_BIT;

  logic [DW-1:0] desc_a, desc_b, ctrl_w, stat_w, sw_w;

  logic sel_a, sel_b, sel_c, sel_s, sel_set, sel_clr, hit;
  assign sel_a   = bus_addr == OFF_DESC_A;
  assign sel_b   = bus_addr == OFF_DESC_B;
  assign sel_c   = bus_addr == OFF_CTRL;
  assign sel_s   = bus_addr == OFF_STAT;
  assign sel_set = bus_addr == OFF_SWSET;
  assign sel_clr = bus_addr == OFF_SWCLR;
  assign hit     = sel_a | sel_b | sel_c | sel_s | sel_set | sel_clr;

  logic raise, lower;
  assign raise = bus_wr & ((sel_b & bus_wdata[RAISE_BIT]) | sel_set);
  assign lower = bus_wr & ((sel_c & bus_wdata[LOWER_BIT]) |
                           (sel_s & (bus_wdata[LOWER_BIT] | bus_wdata[RAISE_BIT])) |
                           sel_clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_a <= '0;
      desc_b <= '0;
      ctrl_w <= '0;
      stat_w <= '0;
      sw_w   <= '0;
      irq_o  <= 1'b0;
    end else begin
      if (bus_wr) begin
        if (sel_a)   desc_a <= bus_wdata;
        if (sel_b)   desc_b <= bus_wdata;
        if (sel_c)   ctrl_w <= bus_wdata;
        if (sel_s)   stat_w <= bus_wdata;
        if (sel_set) sw_w   <= sw_w | bus_wdata;
        if (sel_clr) sw_w   <= sw_w & ~bus_wdata;
      end
      if (raise)      irq_o <= 1'b1;
      else if (lower) irq_o <= 1'b0;
    end
  end

  logic [DW-1:0] rmux;
  always_comb begin
    rmux = '0;
    if (sel_a)             rmux = desc_a;
    if (sel_b)             rmux = desc_b;
    if (sel_c)             rmux = ctrl_w | FIXED_MASK;
    if (sel_s)             rmux = stat_w;
    if (sel_set | sel_clr) rmux = sw_w;
  end
  assign bus_rdata = bus_rd ? rmux : '0;

  p_descb_raise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_DESC_B && bus_wdata[RAISE_BIT]) |=> irq_o);
  p_ctrl_lower_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CTRL && bus_wdata[LOWER_BIT]) |=> !irq_o);
  p_ctrl_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFF_CTRL) |-> bus_rdata[FIXED_BIT]);
  p_stat_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_STAT && (bus_wdata[LOWER_BIT] || bus_wdata[RAISE_BIT])) |=> !irq_o);
  p_swset_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_SWSET) |=> irq_o);
  p_swclr_lower_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_SWCLR) |=> !irq_o);
  p_unmapped_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_rd || !hit) |-> (bus_rdata == '0));
  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_wr || !hit || sel_a) |=> $stable(irq_o));
endmodule

// File: tb/doorbell_regs_tb_top.sv
module doorbell_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        irq_o;

  int vec = 0;
  int bad = 0;
  logic [31:0] m_a, m_b, m_c, m_s, m_w;
  logic        m_irq;

  always #10 clk = ~clk;

  doorbell_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq_o(irq_o));

  function automatic logic [31:0] exp_read(input logic [11:0] a);
    case (a)
      12'h028: return m_a;
      12'h02C: return m_b;
      12'h04C: return m_c | 32'h0002_0000;
      12'h050: return m_s;
      12'h1F0, 12'h1F4: return m_w;
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_of(input logic [11:0] a);
    case (a)
      12'h028: return "R2";
      12'h02C: return "R3";
      12'h04C: return "R4";
      12'h050: return "R5";
      12'h1F0: return "R6";
      12'h1F4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic model_write(input logic [11:0] a, input logic [31:0] d);
    case (a)
      12'h028: m_a = d;
      12'h02C: begin m_b = d; if (d[29]) m_irq = 1'b1; end
      12'h04C: begin m_c = d; if (d[16]) m_irq = 1'b0; end
      12'h050: begin m_s = d; if (d[16] || d[29]) m_irq = 1'b0; end
      12'h1F0: begin m_w = m_w | d; m_irq = 1'b1; end
      12'h1F4: begin m_w = m_w & ~d; m_irq = 1'b0; end
      default: ;
    endcase
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    model_write(a, d);
    chk({tag_of(a), "/R9 irq"}, {31'h0, irq_o}, {31'h0, m_irq});
  endtask

  task automatic do_read(input logic [11:0] a, input string tag);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    chk(tag, bus_rdata, exp_read(a));
    bus_rd = 1'b0;
    #1;
    chk("R8 idle rdata", bus_rdata, 32'h0);
  endtask

  localparam logic [11:0] ADDRS [8] = '{12'h028, 12'h02C, 12'h04C, 12'h050,
                                        12'h1F0, 12'h1F4, 12'h030, 12'h04E};

  initial begin
    m_a = '0; m_b = '0; m_c = '0; m_s = '0; m_w = '0; m_irq = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'h0, irq_o}, 32'h0);
    do_read(12'h04C, "R1 ctrl");
    do_read(12'h028, "R1 descA");
    do_read(12'h02C, "R1 descB");
    do_read(12'h050, "R1 status");
    do_read(12'h1F0, "R1 sw");
    // directed corners
    do_write(12'h1F0, 32'h0);           // R6 zero data still raises
    do_write(12'h028, 32'hFFFF_FFFF);   // R2 no effect on irq
    do_read(12'h028, "R2 readback");
    do_write(12'h030, 32'h2001_0000);   // R8 unmapped write
    do_read(12'h030, "R8 unmapped read");
    do_write(12'h04C, 32'h0000_0000);   // R4 no lower bit: stays high
    do_read(12'h04C, "R4 fixed bit");
    do_write(12'h04C, 32'h0001_0000);   // R4 lower
    do_write(12'h02C, 32'h2000_0000);   // R3 raise
    do_write(12'h050, 32'h2000_0000);   // R5 lower via bit 29
    do_write(12'h02C, 32'h0000_1234);   // R3 no raise
    do_write(12'h1F0, 32'h0000_00F0);
    do_write(12'h1F0, 32'h0000_000F);
    do_read(12'h1F4, "R7 sw read at clr");
    do_write(12'h1F4, 32'h0000_0000);   // R7 always lowers
    do_write(12'h1F4, 32'h0000_0033);
    do_read(12'h1F0, "R7 sw after clear");
    for (int i = 0; i < 5; i++) begin   // R9 hold across idle cycles
      @(negedge clk);
      chk("R9 hold", {31'h0, irq_o}, {31'h0, m_irq});
    end
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 400; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      a = ADDRS[$urandom_range(0, 7)];
      d = $urandom;
      if ($urandom_range(0, 1) == 0) d[29] = 1'b0;
      if ($urandom_range(0, 1) == 0) d[16] = 1'b0;
      do_write(a, d);
      do_read(ADDRS[$urandom_range(0, 7)], "rand read");
    end
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule